// File: doc/BRIEF.md
# Cycle-Stealing Multi-Channel DMA Controller

This block moves data between addresses on a bus it shares with a CPU. It has four independent channels. The DMA side always wins the bus. Each transfer takes single bus cycles from the processor: one read cycle into an internal data latch, then one write cycle from that latch. After the write there is always a released cycle before the next read. Each channel moves either one 16-bit word or one 8-bit byte per request.

Each channel holds a 20-bit source pointer, a 20-bit destination pointer, a 20-bit forward pointer that walks either the source side or the destination side, a 16-bit transfer counter and a 16-bit reload value. A request comes from a software write or from a rising edge on a selected interrupt line. Requests are not queued: a channel keeps at most one pending request. When the counter runs out, the channel rewinds itself for the next block and pulses a done output. A simple write/read register port reaches all channel state. Its address is `{channel, offset}`, with offsets src=0, dst=1, fwd=2 (read only), reload=3, count=4 (read only), control=5 and software request=6.

Top module: `steal_dma`

## Requirements
- R1: After reset there is no bus activity: `bus_req_o`, `rd_o`, `wr_o` and `done_o` are 0. All registers read 0.
- R2: The source and destination pointers (20 bits) and the reload value (16 bits) read back as written.
- R3: Writing control with bit0 (enable) = 1 while the channel is disabled has two effects. It loads the counter from the reload value. It loads the forward pointer from its base: the source pointer if control bit2 = 0, the destination pointer if bit2 = 1.
- R4: A transfer is a read cycle (`rd_o`=1 at the read address) followed in the next cycle by a write cycle (`wr_o`=1 at the write address). The write drives the data sampled during the read. `bus_req_o` is 1 in both cycles and 0 in the cycle after the write.
- R5: Control bit1 selects word mode (1) or byte mode (0). Word mode moves all 16 bits with `byte_o`=0 and a pointer step of 2. Byte mode moves the low 8 bits with zero upper bits, `byte_o`=1 and a step of 1.
- R6: With bit2 = 0 the read address is the forward pointer and the write address is the destination pointer. With bit2 = 1 the read address is the source pointer and the write address is the forward pointer. After each transfer the forward pointer advances by the step and the counter decrements.
- R7: When a transfer brings the counter to zero, three things happen: the counter reloads from the reload value, the forward pointer reloads from its base, and `done_o[ch]` is 1 for exactly the one cycle after the write.
- R8: Writing bit0 = 1 to offset 6 requests one transfer on an enabled channel. The same write on a disabled channel causes no bus activity.
- R9: With control bit3 = 1, a rising edge on `irq_i[sel]` requests one transfer. The select field is control bits [6:5]. A line held high does not request again, and edges on unselected lines are ignored.
- R10: Requests arriving while one is already pending merge into a single transfer. A request arriving in the cycle the read starts, or later, yields one more transfer.
- R11: When several channels are pending, the lowest channel index is served first.
- R12: Control bit4 reads the pending flag. It is 1 after a request and 0 from the first read cycle of the transfer serving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address `{channel[1:0], offset[2:0]}` |
| reg_wdata_i | input | 20 | Register write data |
| reg_rdata_o | output | 20 | Register read data for `reg_addr_i` |
| irq_i | input | 4 | Interrupt request lines, rising edge requests |
| bus_req_o | output | 1 | DMA owns the bus this cycle |
| rd_o | output | 1 | Read cycle strobe |
| wr_o | output | 1 | Write cycle strobe |
| byte_o | output | 1 | Current cycle is a byte access |
| addr_o | output | 20 | Bus address |
| rdata_i | input | 16 | Bus read data, sampled at the end of a read cycle |
| wdata_o | output | 16 | Bus write data from the latch |
| done_o | output | 4 | Per-channel block-complete pulse |

## Verification
Reads return data that depends on the address, so a wrong address or a stale latch shows up in the written value. A word channel walking the source side tells step size and data width apart from a byte channel walking the destination side. Back-to-back software writes, some before and some during a read cycle, separate merging of pending requests from re-arming. Two channels raised by one shared interrupt edge expose the priority order. A held level and an unselected line check that only selected edges count.

// File: rtl/steal_dma_pkg.sv
package steal_dma_pkg;
  typedef enum logic [1:0] {XS_IDLE, XS_RD, XS_WR} xfer_state_e;

  localparam logic [2:0] OFF_SRC   = 3'd0;
  localparam logic [2:0] OFF_DST   = 3'd1;
  localparam logic [2:0] OFF_FWD   = 3'd2;
  localparam logic [2:0] OFF_RLD   = 3'd3;
  localparam logic [2:0] OFF_CNT   = 3'd4;
  localparam logic [2:0] OFF_CTL   = 3'd5;
  localparam logic [2:0] OFF_SWREQ = 3'd6;

  localparam int CB_EN     = 0;
  localparam int CB_WORD   = 1;
  localparam int CB_INCDST = 2;
  localparam int CB_HW     = 3;
  localparam int CB_PEND   = 4;
  localparam int CB_SEL    = 5;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import steal_dma_pkg::*;
#(
  parameter int AW   = 20,
  parameter int CW   = 16,
  parameter int NIRQ = 4,
  parameter int RW   = 20,
  localparam int SELW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      off_i,
  input  logic [RW-1:0]   wdata_i,
  output logic [RW-1:0]   rdata_o,
  input  logic [NIRQ-1:0] irq_rise_i,
  input  logic            start_i,
  input  logic            fin_i,
  output logic            pend_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic            word_o,
  output logic            done_o
);
  logic [AW-1:0]   src_q, dst_q, fwd_q, base, step;
  logic [CW-1:0]   rld_q, cnt_q;
  logic            en_q, word_q, incdst_q, hw_q, pend_q, done_q;
  logic [SELW-1:0] sel_q;
  logic            ctl_wr, sw_req, hw_req, last;

  assign ctl_wr = we_i && (off_i == OFF_CTL);
  assign sw_req = we_i && (off_i == OFF_SWREQ) && wdata_i[0] && en_q;
  assign hw_req = en_q && hw_q && irq_rise_i[sel_q];
  assign base   = incdst_q ? dst_q : src_q;
  assign step   = word_q ? AW'(2) : AW'(1);
  assign last   = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; fwd_q <= '0;
      rld_q <= '0; cnt_q <= '0;
      en_q <= 1'b0; word_q <= 1'b0; incdst_q <= 1'b0; hw_q <= 1'b0;
      sel_q <= '0; pend_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (we_i) begin
        case (off_i)
          OFF_SRC: src_q <= wdata_i[AW-1:0];
          OFF_DST: dst_q <= wdata_i[AW-1:0];
          OFF_RLD: rld_q <= wdata_i[CW-1:0];
          OFF_CTL: begin
            en_q     <= wdata_i[CB_EN];
            word_q   <= wdata_i[CB_WORD];
            incdst_q <= wdata_i[CB_INCDST];
            hw_q     <= wdata_i[CB_HW];
            sel_q    <= wdata_i[CB_SEL +: SELW];
            if (wdata_i[CB_EN] && !en_q) begin
              cnt_q <= rld_q;
              fwd_q <= wdata_i[CB_INCDST] ? dst_q : src_q;
            end
          end
          default: ;
        endcase
      end
      if (fin_i) begin
        if (last) begin
          cnt_q  <= rld_q;
          fwd_q  <= base;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
          fwd_q <= fwd_q + step;
        end
      end
      // new request wins over the clear at read start
      if (ctl_wr && !wdata_i[CB_EN]) pend_q <= 1'b0;
      else if (sw_req || hw_req)     pend_q <= 1'b1;
      else if (start_i)              pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (off_i)
      OFF_SRC: rdata_o = RW'(src_q);
      OFF_DST: rdata_o = RW'(dst_q);
      OFF_FWD: rdata_o = RW'(fwd_q);
      OFF_RLD: rdata_o = RW'(rld_q);
      OFF_CNT: rdata_o = RW'(cnt_q);
      OFF_CTL: rdata_o = RW'({sel_q, pend_q, hw_q, incdst_q, word_q, en_q});
      default: rdata_o = '0;
    endcase
  end

  assign pend_o    = pend_q;
  assign rd_addr_o = incdst_q ? src_q : fwd_q;
  assign wr_addr_o = incdst_q ? fwd_q : dst_q;
  assign word_o    = word_q;
  assign done_o    = done_q;
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] gnt_o,
  output logic           any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import steal_dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 20,
  parameter int DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] gnt_i,
  input  logic           any_i,
  input  logic [AW-1:0]  rd_addr_i [NCH],
  input  logic [AW-1:0]  wr_addr_i [NCH],
  input  logic [NCH-1:0] word_i,
  input  logic [DW-1:0]  rdata_i,
  output logic [NCH-1:0] start_o,
  output logic [NCH-1:0] fin_o,
  output logic           bus_req_o,
  output logic           rd_o,
  output logic           wr_o,
  output logic           byte_o,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  wdata_o
);
  xfer_state_e    state_q;
  logic [CHW-1:0] ch_q, gnt_idx;
  logic [DW-1:0]  latch_q;

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < NCH; i++) if (gnt_i[i]) gnt_idx = CHW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      ch_q    <= '0;
      latch_q <= '0;
    end else begin
      case (state_q)
        XS_IDLE: if (any_i) begin
          state_q <= XS_RD;
          ch_q    <= gnt_idx;
        end
        XS_RD: begin
          latch_q <= word_i[ch_q] ? rdata_i : {{(DW-8){1'b0}}, rdata_i[7:0]};
          state_q <= XS_WR;
        end
        default: state_q <= XS_IDLE;  // one released cycle after every write
      endcase
    end
  end

  assign start_o   = (state_q == XS_IDLE && any_i) ? gnt_i : '0;
  assign fin_o     = (state_q == XS_WR) ? (NCH'(1) << ch_q) : '0;
  assign rd_o      = (state_q == XS_RD);
  assign wr_o      = (state_q == XS_WR);
  assign bus_req_o = rd_o || wr_o;
  assign byte_o    = bus_req_o && !word_i[ch_q];
  assign addr_o    = rd_o ? rd_addr_i[ch_q] : (wr_o ? wr_addr_i[ch_q] : '0);
  assign wdata_o   = latch_q;
endmodule

// File: rtl/steal_dma.sv
module steal_dma
  import steal_dma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NIRQ = 4,
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW = CHW + 3,
  localparam int RW  = AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [RW-1:0]   reg_wdata_i,
  output logic [RW-1:0]   reg_rdata_o,
  input  logic [NIRQ-1:0] irq_i,
  output logic            bus_req_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic            byte_o,
  output logic [AW-1:0]   addr_o,
  input  logic [DW-1:0]   rdata_i,
  output logic [DW-1:0]   wdata_o,
  output logic [NCH-1:0]  done_o
);
  logic [NIRQ-1:0] irq_q, irq_rise;
  logic [NCH-1:0]  ch_we, pend, start, fin, word, gnt;
  logic            any;
  logic [RW-1:0]   ch_rdata [NCH];
  logic [AW-1:0]   rd_addr [NCH];
  logic [AW-1:0]   wr_addr [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end
  assign irq_rise = irq_i & ~irq_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_we[g] = reg_we_i && (reg_addr_i[RAW-1:3] == CHW'(g));
    dma_chan #(.AW(AW), .CW(CW), .NIRQ(NIRQ), .RW(RW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (ch_we[g]),
      .off_i      (reg_addr_i[2:0]),
      .wdata_i    (reg_wdata_i),
      .rdata_o    (ch_rdata[g]),
      .irq_rise_i (irq_rise),
      .start_i    (start[g]),
      .fin_i      (fin[g]),
      .pend_o     (pend[g]),
      .rd_addr_o  (rd_addr[g]),
      .wr_addr_o  (wr_addr[g]),
      .word_o     (word[g]),
      .done_o     (done_o[g])
    );
  end

  assign reg_rdata_o = ch_rdata[reg_addr_i[RAW-1:3]];

  dma_arb #(.NCH(NCH)) u_arb (
    .req_i (pend),
    .gnt_o (gnt),
    .any_o (any)
  );

  dma_xfer #(.NCH(NCH), .AW(AW), .DW(DW)) u_xfer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gnt_i     (gnt),
    .any_i     (any),
    .rd_addr_i (rd_addr),
    .wr_addr_i (wr_addr),
    .word_i    (word),
    .rdata_i   (rdata_i),
    .start_o   (start),
    .fin_o     (fin),
    .bus_req_o (bus_req_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .byte_o    (byte_o),
    .addr_o    (addr_o),
    .wdata_o   (wdata_o)
  );
endmodule

// File: rtl/steal_dma_chk.sv
module steal_dma_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           bus_req_o,
  input logic           rd_o,
  input logic           wr_o,
  input logic           byte_o,
  input logic [DW-1:0]  rdata_i,
  input logic [DW-1:0]  wdata_o,
  input logic [NCH-1:0] done_o
);
  a_r4_rd_then_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o);
  a_r4_release_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !bus_req_o);
  a_r4_no_rd_wr_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  a_r4_word_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !byte_o) |-> wdata_o == $past(rdata_i));
  a_r5_byte_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && byte_o) |-> wdata_o == {{(DW-8){1'b0}}, $past(rdata_i[7:0])});
  a_r7_done_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |-> $past(wr_o));
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
endmodule

bind steal_dma steal_dma_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_req_o (bus_req_o),
  .rd_o      (rd_o),
  .wr_o      (wr_o),
  .byte_o    (byte_o),
  .rdata_i   (rdata_i),
  .wdata_o   (wdata_o),
  .done_o    (done_o)
);

// File: tb/steal_dma_test.sv
module steal_dma_test;
  localparam logic [2:0] SRC = 3'd0, DST = 3'd1, FWD = 3'd2, RLD = 3'd3,
                         CNT = 3'd4, CTL = 3'd5, SWR = 3'd6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  raddr = '0;
  logic [19:0] wdata = '0, rdata_reg;
  logic [3:0]  irq = '0;
  logic        bus_req, rd, wr, bsel;
  logic [19:0] addr;
  logic [15:0] bus_rd, bus_wd;
  logic [3:0]  done;

  always #4 clk = ~clk;

  function automatic logic [15:0] mem_f(input logic [19:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction
  assign bus_rd = mem_f(addr);

  steal_dma uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_reg), .irq_i(irq),
    .bus_req_o(bus_req), .rd_o(rd), .wr_o(wr), .byte_o(bsel),
    .addr_o(addr), .rdata_i(bus_rd), .wdata_o(bus_wd), .done_o(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor, sampled on the falling edge
  logic        ev_wr   [64];
  logic [19:0] ev_addr [64];
  logic [15:0] ev_data [64];
  logic        ev_byte [64];
  int          ev_cyc  [64];
  int ev_n = 0, breq_bad = 0;
  int dn_n [4] = '{0, 0, 0, 0};
  int dn_cyc [4] = '{0, 0, 0, 0};

  always @(negedge clk) if (rst_n) begin
    if (rd || wr) begin
      if (ev_n < 64) begin
        ev_wr[ev_n] = wr; ev_addr[ev_n] = addr; ev_data[ev_n] = bus_wd;
        ev_byte[ev_n] = bsel; ev_cyc[ev_n] = cyc;
      end
      ev_n++;
      if (!bus_req) breq_bad++;
    end else if (bus_req) breq_bad++;
    for (int c = 0; c < 4; c++) if (done[c]) begin dn_n[c]++; dn_cyc[c] = cyc; end
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic reg_wr(input int ch, input logic [2:0] off, input logic [19:0] d);
    we = 1'b1; raddr = {2'(ch), off}; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input int ch, input logic [2:0] off, output logic [19:0] d);
    raddr = {2'(ch), off};
    #1;
    d = rdata_reg;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [19:0] v;
    chk("R1", "bus_req", 32'(bus_req), 0);
    chk("R1", "rd/wr", 32'({rd, wr}), 0);
    chk("R1", "done", 32'(done), 0);
    reg_rd(0, CTL, v); chk("R1", "ch0 ctl", 32'(v), 0);
    reg_rd(1, SRC, v); chk("R1", "ch1 src", 32'(v), 0);
    reg_rd(3, CNT, v); chk("R1", "ch3 cnt", 32'(v), 0);
  endtask

  task automatic t_regs();
    logic [19:0] v;
    reg_wr(1, SRC, 20'hABCDE);
    reg_wr(1, DST, 20'h12345);
    reg_wr(1, RLD, 20'h0BEEF);
    reg_rd(1, SRC, v); chk("R2", "src readback", 32'(v), 32'hABCDE);
    reg_rd(1, DST, v); chk("R2", "dst readback", 32'(v), 32'h12345);
    reg_rd(1, RLD, v); chk("R2", "reload readback", 32'(v), 32'hBEEF);
  endtask

  task automatic t_enable();
    logic [19:0] v;
    reg_wr(0, SRC, 20'h01000); reg_wr(0, DST, 20'h02000);
    reg_wr(0, RLD, 20'd3);     reg_wr(0, CTL, 20'h03);
    reg_rd(0, FWD, v); chk("R3", "ch0 fwd from src", 32'(v), 32'h01000);
    reg_rd(0, CNT, v); chk("R3", "ch0 cnt from reload", 32'(v), 3);
    reg_wr(2, SRC, 20'h05000); reg_wr(2, DST, 20'h06000);
    reg_wr(2, RLD, 20'd4);     reg_wr(2, CTL, 20'h05);
    reg_rd(2, FWD, v); chk("R3", "ch2 fwd from dst", 32'(v), 32'h06000);
    reg_rd(2, CNT, v); chk("R3", "ch2 cnt from reload", 32'(v), 4);
  endtask

  task automatic t_word_xfer();
    int b;
    logic [19:0] v;
    b = ev_n;
    reg_wr(0, SWR, 20'h1);
    wait_cyc(6);
    chk("R4", "event count", 32'(ev_n - b), 2);
    chk("R4", "read cycle first", 32'(ev_wr[b]), 0);
    chk("R6", "read addr = fwd", 32'(ev_addr[b]), 32'h01000);
    chk("R4", "write next cycle", 32'(ev_cyc[b+1] - ev_cyc[b]), 1);
    chk("R6", "write addr = dst", 32'(ev_addr[b+1]), 32'h02000);
    chk("R5", "word data", 32'(ev_data[b+1]), 32'(mem_f(20'h01000)));
    chk("R5", "word byte_o", 32'(ev_byte[b+1]), 0);
    reg_rd(0, FWD, v); chk("R6", "fwd +2", 32'(v), 32'h01002);
    reg_rd(0, CNT, v); chk("R6", "cnt -1", 32'(v), 2);
  endtask

  task automatic t_block_end();
    int d0, b;
    logic [19:0] v;
    d0 = dn_n[0];
    reg_wr(0, SWR, 20'h1); wait_cyc(6);
    chk("R7", "no done mid block", 32'(dn_n[0] - d0), 0);
    b = ev_n;
    reg_wr(0, SWR, 20'h1); wait_cyc(6);
    chk("R6", "read addr +4", 32'(ev_addr[b]), 32'h01004);
    chk("R7", "done one cycle", 32'(dn_n[0] - d0), 1);
    chk("R7", "done after write", 32'(dn_cyc[0] - ev_cyc[b+1]), 1);
    reg_rd(0, CNT, v); chk("R7", "cnt reloaded", 32'(v), 3);
    reg_rd(0, FWD, v); chk("R7", "fwd rewound", 32'(v), 32'h01000);
  endtask

  task automatic t_byte_pend();
    int b;
    logic [19:0] v;
    b = ev_n;
    reg_wr(2, SWR, 20'h1);
    reg_rd(2, CTL, v); chk("R12", "pending set", 32'(v[4]), 1);
    @(negedge clk);
    chk("R12", "rd in first cycle", 32'(rd), 1);
    reg_rd(2, CTL, v); chk("R12", "pending cleared at read", 32'(v[4]), 0);
    wait_cyc(4);
    chk("R6", "ch2 read addr = src", 32'(ev_addr[b]), 32'h05000);
    chk("R6", "ch2 write addr = fwd", 32'(ev_addr[b+1]), 32'h06000);
    chk("R5", "byte data", 32'(ev_data[b+1]), 32'(mem_f(20'h05000) & 16'h00FF));
    chk("R5", "byte_o", 32'(ev_byte[b+1]), 1);
    reg_rd(2, FWD, v); chk("R5", "fwd +1", 32'(v), 32'h06001);
  endtask

  task automatic t_disabled();
    int b;
    logic [19:0] v;
    reg_wr(3, RLD, 20'd5);
    b = ev_n;
    reg_wr(3, SWR, 20'h1);
    wait_cyc(8);
    chk("R8", "no bus on disabled ch", 32'(ev_n - b), 0);
    reg_rd(3, CTL, v); chk("R8", "no pending", 32'(v[4]), 0);
  endtask

  task automatic t_hw();
    int b;
    reg_wr(1, SRC, 20'h11000); reg_wr(1, DST, 20'h12000);
    reg_wr(1, RLD, 20'd10);    reg_wr(1, CTL, 20'h4B);
    b = ev_n;
    irq[2] = 1'b1; wait_cyc(12);
    chk("R9", "one transfer per edge", 32'(ev_n - b), 2);
    chk("R9", "hw read addr", 32'(ev_addr[b]), 32'h11000);
    irq[2] = 1'b0; wait_cyc(2);
    b = ev_n;
    irq[1] = 1'b1; wait_cyc(6); irq[1] = 1'b0; wait_cyc(2);
    chk("R9", "unselected line ignored", 32'(ev_n - b), 0);
  endtask

  task automatic t_priority();
    int b;
    reg_wr(3, SRC, 20'h31000); reg_wr(3, DST, 20'h32000);
    reg_wr(3, CTL, 20'h4B);
    b = ev_n;
    irq[2] = 1'b1; wait_cyc(12); irq[2] = 1'b0; wait_cyc(2);
    chk("R11", "transfer count", 32'(ev_n - b), 4);
    chk("R11", "ch1 first", 32'(ev_addr[b]), 32'h11002);
    chk("R11", "ch3 second", 32'(ev_addr[b+2]), 32'h31000);
  endtask

  task automatic t_collapse();
    int b;
    b = ev_n;
    reg_wr(0, SWR, 20'h1);
    reg_wr(0, SWR, 20'h1);  // lands as the read starts: re-arms
    reg_wr(1, SWR, 20'h1);
    reg_wr(1, SWR, 20'h1);  // merges with the one already pending
    wait_cyc(14);
    chk("R10", "transfer events", 32'(ev_n - b), 6);
    chk("R10", "ch0 first", 32'(ev_addr[b]), 32'h01000);
    chk("R10", "ch0 re-armed", 32'(ev_addr[b+2]), 32'h01002);
    chk("R10", "ch1 once", 32'(ev_addr[b+4]), 32'h11004);
  endtask

  task automatic run_all();
    t_reset();
    t_regs();
    t_enable();
    t_word_xfer();
    t_block_end();
    t_byte_pend();
    t_disabled();
    t_hw();
    t_priority();
    t_collapse();
    chk("R4", "bus_req matches rd/wr", 32'(breq_bad), 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule